// File: doc/BRIEF.md
# Cascaded Display Sync Counter Bank

The block is a bank of programmable timing counters that together generate the synchronisation waveforms of a raster display and the per-pixel request strobe for the display controller. Counter 0 is the time base and produces one tick in every enabled clock cycle. Every other counter advances on a selectable step source. That source is the pixel tick or the event strobe of a lower-numbered counter, so the counters form a chain: line counters step on pixels, and frame counters step on line events.

Each counter can be programmed with a run value, an offset, a repeat count, a restart source and a pin window. The run value sets its period. The offset swallows step ticks after the counter starts. The repeat count limits how many events it emits. The restart source names a lower-numbered counter whose event re-arms it. The pin window uses positions in half-step units. With this one mechanism the bank produces the horizontal and vertical sync pulses and also the active-frame and active-line gating. The active-line counter's event is the pixel request. It is a plain single-cycle strobe: there is no ready and no back-pressure, so the display controller must accept each request in the cycle it is raised.

Configuration goes through a simple register-write port. A write takes effect only while the bank is disabled. Deasserting the enable returns every counter to idle.

Top module: `sync_timer_bank`

## Requirements
- R1: While `en_i` is low, `ev_o`, `hsync_o`, `vsync_o` and `pix_req_o` are all 0. While `en_i` is high, `ev_o[0]` is 1 in every cycle (pixel tick).
- R2: A counter whose run value is N-1 emits one event on every N-th tick of its step source once its offset has elapsed. A run value of 0 fires on every step tick.
- R3: Step-source code s (field 3) selects the event of counter s when s is less than the counter's own index, with code 0 meaning the pixel tick. Any other code selects the pixel tick. An event occurs only in a cycle in which the step source fires, in that same cycle, with no added latency per chain level.
- R4: After a counter starts, it swallows its first O step ticks (offset field 1) before phase counting begins. With run value R, the first event therefore falls on step tick O+R+1.
- R5: A non-zero repeat count C (field 2) allows exactly C events and then silences the counter until a restart. A repeat count of 0 repeats without limit.
- R6: Restart code r (field 4) with r below the counter's own index restarts the counter on every event of counter r. A restart clears the counter's offset, phase and repeat progress, and the counter emits no event in the restart cycle. Any other code means no restart source. A counter that has a restart source stays idle from enable until its first restart. A counter without one starts at enable.
- R7: When the counter's pin-enable bit (field 7, bit 0) is set, its pin is high while the counter is running past its offset, not silenced, and twice its phase lies in [up, down) (fields 5 and 6). `hsync_o` is the pin of counter 2 and `vsync_o` is the pin of counter 3.
- R8: `pix_req_o` equals the event strobe of counter 5. It is one cycle long per active pixel.
- R9: A write is accepted only when `cfg_we_i` is high, `en_i` is low, and `cfg_idx_i` is between 1 and 5. Writes to counter 0, to indices 6 and 7, or made while enabled have no effect. Field codes are: 0 run, 1 offset, 2 repeat, 3 step source, 4 restart source, 5 pin up, 6 pin down, 7 pin enable.
- R10: After reset, every counter has run 0, offset 0, repeat 0, step source pixel, restart none (all ones), pin up 0, pin down 0 and pin disabled. Enabling the bank with this configuration makes every counter fire on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Bank enable; low holds all counters idle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W (3) | Counter index of the write |
| cfg_field_i | input | 3 | Field code of the write |
| cfg_data_i | input | CW+1 (13) | Write data |
| hsync_o | output | 1 | Horizontal sync pin (counter 2) |
| vsync_o | output | 1 | Vertical sync pin (counter 3) |
| pix_req_o | output | 1 | Pixel request strobe (counter 5 event) |
| ev_o | output | NUM_CNT (6) | Event strobes of all counters |

## Verification
The checker enforces the following on every cycle:
- All outputs are quiet while the bank is disabled.
- A counter fires only together with its selected step source.
- A restart event masks the restarted counter's own event.
- Configuration holds still while the bank is enabled.
- A counter never exceeds its repeat count between restarts.

Exact periods, offsets, pin windows and the idle-until-restart start are checked by the bench. Its behavioural model compares every output each cycle across a display-like cascade, an unusual configuration with odd pin edges and out-of-range codes, ignored writes, and enable toggling in the middle of a frame.

// File: rtl/sync_bank_pkg.sv
package sync_bank_pkg;
  typedef enum logic [2:0] {
    FLD_RUN     = 3'd0,
    FLD_OFFSET  = 3'd1,
    FLD_REPEAT  = 3'd2,
    FLD_STEP    = 3'd3,
    FLD_RESTART = 3'd4,
    FLD_UP      = 3'd5,
    FLD_DOWN    = 3'd6,
    FLD_PIN     = 3'd7
  } cfg_field_e;
endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
  import sync_bank_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int CW      = 12,
  parameter int SW      = 3,
  parameter int IDX_W   = 3,
  parameter int DW      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       field_i,
  input  logic [DW-1:0]    data_i,
  output logic [CW-1:0]    run_o   [NUM_CNT],
  output logic [CW-1:0]    off_o   [NUM_CNT],
  output logic [CW-1:0]    rep_o   [NUM_CNT],
  output logic [SW-1:0]    step_o  [NUM_CNT],
  output logic [SW-1:0]    rst_o   [NUM_CNT],
  output logic [DW-1:0]    up_o    [NUM_CNT],
  output logic [DW-1:0]    dn_o    [NUM_CNT],
  output logic             pen_o   [NUM_CNT]
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    if (k == 0) begin : g_base
      // the time base has no programmable state
      assign run_o[k]  = '0;
      assign off_o[k]  = '0;
      assign rep_o[k]  = '0;
      assign step_o[k] = '0;
      assign rst_o[k]  = '1;
      assign up_o[k]   = '0;
      assign dn_o[k]   = '0;
      assign pen_o[k]  = 1'b0;
    end else begin : g_prog
      logic [CW-1:0] run_q, off_q, rep_q;
      logic [SW-1:0] step_q, rst_q;
      logic [DW-1:0] up_q, dn_q;
      logic          pen_q;
      logic          hit;

      assign hit = we_i && !en_i && (idx_i == IDX_W'(k));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q  <= '0;
          off_q  <= '0;
          rep_q  <= '0;
          step_q <= '0;
          rst_q  <= '1;
          up_q   <= '0;
          dn_q   <= '0;
          pen_q  <= 1'b0;
        end else if (hit) begin
          case (cfg_field_e'(field_i))
            FLD_RUN:     run_q  <= data_i[CW-1:0];
            FLD_OFFSET:  off_q  <= data_i[CW-1:0];
            FLD_REPEAT:  rep_q  <= data_i[CW-1:0];
            FLD_STEP:    step_q <= data_i[SW-1:0];
            FLD_RESTART: rst_q  <= data_i[SW-1:0];
            FLD_UP:      up_q   <= data_i;
            FLD_DOWN:    dn_q   <= data_i;
            FLD_PIN:     pen_q  <= data_i[0];
            default: ;
          endcase
        end
      end

      assign run_o[k]  = run_q;
      assign off_o[k]  = off_q;
      assign rep_o[k]  = rep_q;
      assign step_o[k] = step_q;
      assign rst_o[k]  = rst_q;
      assign up_o[k]   = up_q;
      assign dn_o[k]   = dn_q;
      assign pen_o[k]  = pen_q;
    end
  end
endmodule

// File: rtl/sync_counter.sv
module sync_counter #(
  parameter int CW = 12,
  parameter int DW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic          has_restart_i,
  input  logic [CW-1:0] run_i,
  input  logic [CW-1:0] offset_i,
  input  logic [CW-1:0] repeat_i,
  input  logic [DW-1:0] up_i,
  input  logic [DW-1:0] down_i,
  input  logic          pin_en_i,
  output logic          ev_o,
  output logic          pin_o
);
  logic          started_q, done_q;
  logic [CW-1:0] off_q, phase_q, reps_q;
  logic          armed, off_done, at_end, live;
  logic [DW-1:0] half_pos;

  // a counter without restart source runs from enable on
  assign armed    = started_q || !has_restart_i;
  assign off_done = (off_q == offset_i);
  assign at_end   = (phase_q == run_i);
  assign live     = en_i && armed && !done_q;
  assign ev_o     = live && step_i && !restart_i && off_done && at_end;

  // edge positions are in half-step units
  assign half_pos = {phase_q, 1'b0};
  assign pin_o    = pin_en_i && live && off_done &&
                    (half_pos >= up_i) && (half_pos < down_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      started_q <= 1'b0;
      done_q    <= 1'b0;
      off_q     <= '0;
      phase_q   <= '0;
      reps_q    <= '0;
    end else if (restart_i) begin
      started_q <= 1'b1;
      done_q    <= 1'b0;
      off_q     <= '0;
      phase_q   <= '0;
      reps_q    <= '0;
    end else if (armed && step_i && !done_q) begin
      if (!off_done) begin
        off_q <= off_q + CW'(1);
      end else if (at_end) begin
        phase_q <= '0;
        reps_q  <= reps_q + CW'(1);
        if ((repeat_i != '0) && (reps_q + CW'(1) == repeat_i))
          done_q <= 1'b1;
      end else begin
        phase_q <= phase_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_timer_bank.sv
module sync_timer_bank
  import sync_bank_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int CW      = 12,
  parameter int HS_SEL  = 2,
  parameter int VS_SEL  = 3,
  parameter int REQ_SEL = 5,
  localparam int IDX_W  = $clog2(NUM_CNT),
  localparam int SW     = IDX_W,
  localparam int DW     = CW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [2:0]         cfg_field_i,
  input  logic [DW-1:0]      cfg_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               pix_req_o,
  output logic [NUM_CNT-1:0] ev_o
);
  logic [NUM_CNT-1:0] ev_w, pin_w;
  logic [CW-1:0] run_cfg  [NUM_CNT];
  logic [CW-1:0] off_cfg  [NUM_CNT];
  logic [CW-1:0] rep_cfg  [NUM_CNT];
  logic [SW-1:0] step_sel [NUM_CNT];
  logic [SW-1:0] rst_sel  [NUM_CNT];
  logic [DW-1:0] up_cfg   [NUM_CNT];
  logic [DW-1:0] dn_cfg   [NUM_CNT];
  logic          pen_cfg  [NUM_CNT];

  sync_cfg_regs #(
    .NUM_CNT(NUM_CNT), .CW(CW), .SW(SW), .IDX_W(IDX_W), .DW(DW)
  ) i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .field_i(cfg_field_i),
    .data_i (cfg_data_i),
    .run_o  (run_cfg),
    .off_o  (off_cfg),
    .rep_o  (rep_cfg),
    .step_o (step_sel),
    .rst_o  (rst_sel),
    .up_o   (up_cfg),
    .dn_o   (dn_cfg),
    .pen_o  (pen_cfg)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == 0) begin : g_tick
      assign ev_w[k]  = en_i;
      assign pin_w[k] = 1'b0;
    end else begin : g_chain
      logic step_k, rst_k, has_rst_k;

      // only lower counters can be selected: the chain stays acyclic
      always_comb begin
        step_k = ev_w[0];
        rst_k  = 1'b0;
        for (int j = 1; j < k; j++)
          if (step_sel[k] == SW'(j)) step_k = ev_w[j];
        for (int j = 0; j < k; j++)
          if (rst_sel[k] == SW'(j)) rst_k = ev_w[j];
      end
      assign has_rst_k = (rst_sel[k] < SW'(k));

      sync_counter #(.CW(CW), .DW(DW)) i_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .step_i       (step_k),
        .restart_i    (rst_k),
        .has_restart_i(has_rst_k),
        .run_i        (run_cfg[k]),
        .offset_i     (off_cfg[k]),
        .repeat_i     (rep_cfg[k]),
        .up_i         (up_cfg[k]),
        .down_i       (dn_cfg[k]),
        .pin_en_i     (pen_cfg[k]),
        .ev_o         (ev_w[k]),
        .pin_o        (pin_w[k])
      );
    end
  end

  assign ev_o      = ev_w;
  assign hsync_o   = pin_w[HS_SEL];
  assign vsync_o   = pin_w[VS_SEL];
  assign pix_req_o = ev_w[REQ_SEL];
endmodule

// File: rtl/sync_timer_bank_chk.sv
module sync_timer_bank_chk #(
  parameter int NUM_CNT = 6,
  parameter int CW      = 12,
  parameter int SW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic [NUM_CNT-1:0] ev_o,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               pix_req_o,
  input logic [SW-1:0]      step_sel [NUM_CNT],
  input logic [SW-1:0]      rst_sel  [NUM_CNT],
  input logic [CW-1:0]      run_cfg  [NUM_CNT],
  input logic [CW-1:0]      rep_cfg  [NUM_CNT]
);
  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (ev_o == '0 && !hsync_o && !vsync_o && !pix_req_o)); // R1

  for (genvar k = 1; k < NUM_CNT; k++) begin : g_chk
    logic [31:0] evn_q;

    always_ff @(posedge clk) begin
      if (!rst_n || !en_i)
        evn_q <= '0;
      else if ((rst_sel[k] < SW'(k)) && ev_o[rst_sel[k]])
        evn_q <= '0;
      else if (ev_o[k])
        evn_q <= evn_q + 32'd1;
    end

    AST_STEP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o[k] && (step_sel[k] < SW'(k))) |-> ev_o[step_sel[k]]); // R3

    AST_RESTART_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_sel[k] < SW'(k)) && ev_o[rst_sel[k]]) |-> !ev_o[k]); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> ($stable(run_cfg[k]) && $stable(rep_cfg[k]))); // R9

    AST_REPEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cfg[k] != '0) |-> (evn_q <= 32'(rep_cfg[k]))); // R5
  end
endmodule

bind sync_timer_bank sync_timer_bank_chk #(
  .NUM_CNT(NUM_CNT), .CW(CW), .SW(SW)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .ev_o     (ev_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .pix_req_o(pix_req_o),
  .step_sel (step_sel),
  .rst_sel  (rst_sel),
  .run_cfg  (run_cfg),
  .rep_cfg  (rep_cfg)
);

// File: tb/test_sync_timer_bank.sv
module test_sync_timer_bank;
  localparam int NC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_field = '0;
  logic [12:0] cfg_data = '0;
  logic       hsync, vsync, pix_req;
  logic [NC-1:0] ev;

  int checks = 0;
  int errors = 0;
  string scen = "R10";

  // shadow configuration and behavioural state
  int c_run[NC], c_off[NC], c_rep[NC], c_stp[NC], c_rst[NC], c_up[NC], c_dn[NC], c_pen[NC];
  int m_ticks[NC];
  bit m_started[NC];
  bit e_ev[NC];
  bit e_pin[NC];

  always #10 clk = ~clk;

  sync_timer_bank i_sync_timer_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .cfg_we_i   (cfg_we),
    .cfg_idx_i  (cfg_idx),
    .cfg_field_i(cfg_field),
    .cfg_data_i (cfg_data),
    .hsync_o    (hsync),
    .vsync_o    (vsync),
    .pix_req_o  (pix_req),
    .ev_o       (ev)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic defaults();
    for (int k = 0; k < NC; k++) begin
      c_run[k] = 0; c_off[k] = 0; c_rep[k] = 0; c_stp[k] = 0;
      c_rst[k] = 7; c_up[k] = 0; c_dn[k] = 0; c_pen[k] = 0;
      m_ticks[k] = 0; m_started[k] = 0;
    end
  endtask

  task automatic apply_write();
    int i;
    i = int'(cfg_idx);
    if (cfg_we && i >= 1 && i < NC) begin
      case (int'(cfg_field))
        0: c_run[i] = int'(cfg_data[11:0]);
        1: c_off[i] = int'(cfg_data[11:0]);
        2: c_rep[i] = int'(cfg_data[11:0]);
        3: c_stp[i] = int'(cfg_data[2:0]);
        4: c_rst[i] = int'(cfg_data[2:0]);
        5: c_up[i]  = int'(cfg_data);
        6: c_dn[i]  = int'(cfg_data);
        default: c_pen[i] = int'(cfg_data[0]);
      endcase
    end
  endtask

  // reference model: outputs from state before the coming edge, then advance
  always @(negedge clk) begin
    int exp_vec;
    for (int k = 0; k < NC; k++) begin e_ev[k] = 0; e_pin[k] = 0; end
    if (!rst_n) begin
      defaults();
    end else if (!en) begin
      for (int k = 0; k < NC; k++) begin m_ticks[k] = 0; m_started[k] = 0; end
      apply_write();
    end else begin
      bit nxt_rs[NC];
      bit nxt_step[NC];
      bit nxt_live[NC];
      e_ev[0] = 1;
      for (int k = 1; k < NC; k++) begin
        int per, rel, ph;
        bit armed, done, stp, rs;
        stp = (c_stp[k] < k) ? e_ev[c_stp[k]] : e_ev[0];
        rs = (c_rst[k] < k) ? e_ev[c_rst[k]] : 1'b0;
        armed = m_started[k] || (c_rst[k] >= k);
        per = c_run[k] + 1;
        rel = m_ticks[k] - c_off[k];
        ph = (rel >= 0) ? rel % per : 0;
        done = (c_rep[k] != 0) && (rel >= 0) && (rel / per >= c_rep[k]);
        e_ev[k] = armed && stp && !rs && (rel >= 0) && !done && (ph == c_run[k]);
        e_pin[k] = (c_pen[k] != 0) && armed && (rel >= 0) && !done &&
                   (2 * ph >= c_up[k]) && (2 * ph < c_dn[k]);
        nxt_rs[k] = rs;
        nxt_step[k] = stp;
        nxt_live[k] = armed && !done;
      end
      for (int k = 1; k < NC; k++) begin
        if (nxt_rs[k]) begin
          m_started[k] = 1; m_ticks[k] = 0;
        end else if (nxt_live[k] && nxt_step[k]) begin
          m_ticks[k] = m_ticks[k] + 1;
        end
      end
    end
    exp_vec = 0;
    for (int k = 0; k < NC; k++) if (e_ev[k]) exp_vec |= (1 << k);
    if (!en) begin
      check({scen, " R1"}, "idle ev_o", int'(ev), 0);
      check({scen, " R1"}, "idle pins", int'({hsync, vsync, pix_req}), 0);
    end else begin
      check({scen, " R2/R3/R4/R5/R6"}, "ev_o", int'(ev), exp_vec);
      check({scen, " R7"}, "hsync_o", int'(hsync), int'(e_pin[2]));
      check({scen, " R7"}, "vsync_o", int'(vsync), int'(e_pin[3]));
      check({scen, " R8"}, "pix_req_o", int'(pix_req), int'(e_ev[5]));
    end
  end

  task automatic wr(int idx, int fld, int val);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_field = 3'(fld); cfg_data = 13'(val);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic set_en(bit v);
    @(posedge clk); #2;
    en = v;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL [watchdog] run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    defaults();
    // R10: reset state
    cycles(4);
    #5;
    check("R10", "reset ev_o", int'(ev), 0);
    check("R10", "reset pins", int'({hsync, vsync, pix_req}), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    cycles(2);
    // R10: default configuration fires every counter on every cycle
    set_en(1'b1);
    cycles(3);
    #5;
    check("R10", "default all fire", int'(ev), 63);
    set_en(1'b0);

    // display-style cascade; R3 selects line events for the frame counters
    scen = "R3 R6";
    wr(1, 0, 9);
    wr(2, 0, 9); wr(2, 1, 2); wr(2, 5, 0); wr(2, 6, 4); wr(2, 7, 1);
    wr(3, 3, 1); wr(3, 0, 7); wr(3, 5, 0); wr(3, 6, 2); wr(3, 7, 1);
    wr(4, 3, 1); wr(4, 0, 0); wr(4, 1, 2); wr(4, 2, 4); wr(4, 4, 3);
    wr(5, 3, 0); wr(5, 0, 0); wr(5, 1, 3); wr(5, 2, 5); wr(5, 4, 4);
    scen = "R2 R4 R5 R6 R7 R8";
    set_en(1'b1);
    cycles(300);

    // R9: writes while enabled are ignored
    scen = "R9";
    wr(1, 0, 3);
    wr(5, 2, 1);
    cycles(100);

    scen = "R1";
    set_en(1'b0);
    cycles(5);

    // odd configuration: out-of-range codes, limited repeats, odd edges
    scen = "R9";
    wr(0, 0, 5);
    wr(6, 0, 1);
    wr(7, 2, 1);
    scen = "R3 R5 R7";
    wr(1, 3, 6); wr(1, 0, 2); wr(1, 4, 7);
    wr(2, 3, 1); wr(2, 0, 1); wr(2, 2, 3); wr(2, 1, 1);
    wr(2, 5, 1); wr(2, 6, 3); wr(2, 4, 7);
    wr(3, 3, 0); wr(3, 0, 4); wr(3, 4, 1); wr(3, 5, 0); wr(3, 6, 5);
    wr(4, 3, 0); wr(4, 0, 1); wr(4, 2, 0); wr(4, 4, 2); wr(4, 1, 0);
    wr(5, 3, 4); wr(5, 0, 0); wr(5, 2, 2); wr(5, 4, 1); wr(5, 1, 1);
    set_en(1'b1);
    cycles(200);

    // R1 R6: enable toggled in mid-pattern returns counters to idle
    scen = "R1 R6";
    set_en(1'b0);
    cycles(2);
    set_en(1'b1);
    cycles(100);
    set_en(1'b0);
    cycles(3);

    summary();
    $finish;
  end
endmodule